// File: doc/BRIEF.md
# Indirect Image-Buffer Descriptor Table

The block keeps a table of image-buffer descriptors. Each descriptor holds a base address, a line width, a height, a wrap mode, a block-mode code and an optional byte-swap code. Software reaches the table through three 32-bit registers on a simple register bus. It writes a descriptor into two staging words. It then writes a command word that carries an entry index and a commit bit. The commit moves both staging words into that entry in a single step, so a descriptor is never half updated. A load bit in the same command word does the reverse: it copies an entry back into the staging words, where software can read it.

A separate lookup port serves a memory client. The client presents an index, and one cycle later the decoded fields of that entry appear. The line width is split across the two staging words: its three low bits sit at the top of the low word and the rest sit at the bottom of the high word. The lookup port joins the two parts into one 12-bit value. A build parameter decides whether the byte-swap field is stored. When it is not stored, that field reads as zero everywhere.

Top module: `desc_table`

## Requirements
- R1: After reset, every table entry, both staging words and the stored index are zero. All register reads and all lookup outputs are then zero.
- R2: A bus write at offset 0x0 sets the low staging word and a write at 0x4 sets the high staging word. Reads at 0x0 and 0x4 return those words. Reads at any offset other than 0x0, 0x4 or 0x8 return zero, and writes there have no effect.
- R3: A write to offset 0x8 with bit 9 set copies both staging words into the entry selected by bits 7:0. A later lookup of that index returns the committed fields, and a read of the high word returns the committed value.
- R4: In the low word, bits 28:0 are the base address in 8-byte units and bits 31:29 are width bits 2:0. Lookup width equals {high[8:0], low[31:29]}.
- R5: In the high word, bits 21:9 are the height, bits 23:22 the wrap mode and bits 25:24 the block mode. Bits 31:30 are never stored and read as zero.
- R6: High-word bits 29:26 are the byte-swap code when HAS_ENDIAN=1. When HAS_ENDIAN=0, writes to those bits are ignored, and they read as zero both on the bus and on the lookup port.
- R7: A write to offset 0x8 with bit 8 set and bit 9 clear loads the selected entry into both staging words, visible from the next cycle. When bits 8 and 9 are both set, the commit happens and the staging words stay unchanged.
- R8: A read at offset 0x8 returns the index from the last command write in bits 7:0, with all other bits zero, including the command bits.
- R9: The lookup outputs show the fields of the entry at lk_idx, registered one cycle after lk_idx is presented.
- R10: When a commit to index N happens in the same cycle as a lookup of N, the lookup returns the newly committed descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| lk_idx | input | 8 | Lookup index |
| lk_base | output | 29 | Base address of the looked-up entry, 8-byte units |
| lk_width | output | 12 | Line width, 8-byte units |
| lk_height | output | 13 | Height |
| lk_wrap | output | 2 | Wrap mode |
| lk_blkmode | output | 2 | Block mode |
| lk_endian | output | 4 | Byte-swap code, zero when HAS_ENDIAN=0 |

## Verification
Two events can fall in the same cycle: a commit from the command register, and a lookup of the same index on the client port. The bench provokes this on purpose by setting lk_idx to the commit target in the command cycle. It also does so by chance, in a long random run over a small index set. It judges the result against a behavioural model that applies the commit before the lookup in the same cycle. The load and commit bits are also set together, and the bench checks that the staging words keep their values while the entry still changes.

// File: rtl/desc_table.sv
module desc_table #(
  parameter int ENTRIES    = 256,
  parameter bit HAS_ENDIAN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  lk_idx,
  output logic [28:0] lk_base,
  output logic [11:0] lk_width,
  output logic [12:0] lk_height,
  output logic [1:0]  lk_wrap,
  output logic [1:0]  lk_blkmode,
  output logic [3:0]  lk_endian
);
  localparam int IDXW = $clog2(ENTRIES);
  localparam logic [31:0] HI_MASK = HAS_ENDIAN ? 32'h3FFF_FFFF : 32'h03FF_FFFF;

  logic [31:0] stg_lo, stg_hi;
  logic [IDXW-1:0] cur_idx;
  logic [31:0] tab_lo [ENTRIES];
  logic [31:0] tab_hi [ENTRIES];
  logic [31:0] lk_lo, lk_hi;

  wire wr_lo = bus_wr && bus_addr == 4'h0;
  wire wr_hi = bus_wr && bus_addr == 4'h4;
  wire cmd   = bus_wr && bus_addr == 4'h8;
  wire [IDXW-1:0] cmd_idx = bus_wdata[IDXW-1:0];
  wire [IDXW-1:0] rd_idx  = lk_idx[IDXW-1:0];
  wire do_wr = cmd && bus_wdata[9];
  wire do_rd = cmd && bus_wdata[8] && !bus_wdata[9];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_lo  <= '0;
      stg_hi  <= '0;
      cur_idx <= '0;
    end else begin
      if (wr_lo) stg_lo <= bus_wdata;
      else if (do_rd) stg_lo <= tab_lo[cmd_idx];
      if (wr_hi) stg_hi <= bus_wdata & HI_MASK;
      else if (do_rd) stg_hi <= tab_hi[cmd_idx];
      if (cmd) cur_idx <= cmd_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tab_lo[i] <= '0;
        tab_hi[i] <= '0;
      end
    end else if (do_wr) begin
      tab_lo[cmd_idx] <= stg_lo;
      tab_hi[cmd_idx] <= stg_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_lo <= '0;
      lk_hi <= '0;
    end else if (do_wr && cmd_idx == rd_idx) begin
      lk_lo <= stg_lo;
      lk_hi <= stg_hi;
    end else begin
      lk_lo <= tab_lo[rd_idx];
      lk_hi <= tab_hi[rd_idx];
    end
  end

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = stg_lo;
      4'h4:    bus_rdata = stg_hi;
      4'h8:    bus_rdata = 32'(cur_idx);
      default: bus_rdata = '0;
    endcase
  end

  assign lk_base    = lk_lo[28:0];
  assign lk_width   = {lk_hi[8:0], lk_lo[31:29]};
  assign lk_height  = lk_hi[21:9];
  assign lk_wrap    = lk_hi[23:22];
  assign lk_blkmode = lk_hi[25:24];
  assign lk_endian  = lk_hi[29:26];

  a_r3_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(do_wr) |->
      tab_lo[$past(cmd_idx)] == $past(stg_lo) && tab_hi[$past(cmd_idx)] == $past(stg_hi));

  a_r7_load_staging: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(do_rd) |->
      stg_lo == $past(tab_lo[cmd_idx]) && stg_hi == $past(tab_hi[cmd_idx]));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cmd && bus_wdata[9] && bus_wdata[8]) |->
      $stable(stg_lo) && $stable(stg_hi));

  a_r10_forward: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(do_wr && cmd_idx == rd_idx) |->
      lk_base == $past(stg_lo[28:0]) && lk_height == $past(stg_hi[21:9]));

  a_r8_index_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 4'h8 |-> bus_rdata[31:IDXW] == '0);

  a_r5_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 4'h4 |-> bus_rdata[31:30] == 2'b00);
endmodule

// File: tb/desc_table_test.sv
module desc_table_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [7:0] lk_idx = '0;
  logic [31:0] rd [2];
  logic [28:0] base [2];
  logic [11:0] width [2];
  logic [12:0] height [2];
  logic [1:0] wrap [2], blk [2];
  logic [3:0] endn [2];

  always #10 clk = ~clk;

  desc_table #(.ENTRIES(256), .HAS_ENDIAN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd[0]), .lk_idx(lk_idx), .lk_base(base[0]), .lk_width(width[0]),
    .lk_height(height[0]), .lk_wrap(wrap[0]), .lk_blkmode(blk[0]), .lk_endian(endn[0]));

  desc_table #(.ENTRIES(256), .HAS_ENDIAN(1'b0)) uut_noend (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd[1]), .lk_idx(lk_idx), .lk_base(base[1]), .lk_width(width[1]),
    .lk_height(height[1]), .lk_wrap(wrap[1]), .lk_blkmode(blk[1]), .lk_endian(endn[1]));

  int vectors = 0;
  int fails = 0;
  string phase = "R1";

  bit [31:0] m_lo [2][256];
  bit [31:0] m_hi [2][256];
  bit [31:0] s_lo [2], s_hi [2], e_lo [2], e_hi [2];
  bit [7:0] m_idx;

  function automatic bit [31:0] hmask(int v);
    return (v == 0) ? 32'h3FFF_FFFF : 32'h03FF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        for (int i = 0; i < 256; i++) begin m_lo[v][i] = 0; m_hi[v][i] = 0; end
        s_lo[v] = 0; s_hi[v] = 0; e_lo[v] = 0; e_hi[v] = 0;
      end
      m_idx = 0;
    end else begin
      for (int v = 0; v < 2; v++) begin
        if (bus_wr && bus_addr == 4'h0) s_lo[v] = bus_wdata;
        if (bus_wr && bus_addr == 4'h4) s_hi[v] = bus_wdata & hmask(v);
        if (bus_wr && bus_addr == 4'h8) begin
          if (bus_wdata[9]) begin
            m_lo[v][bus_wdata[7:0]] = s_lo[v];
            m_hi[v][bus_wdata[7:0]] = s_hi[v];
          end else if (bus_wdata[8]) begin
            s_lo[v] = m_lo[v][bus_wdata[7:0]];
            s_hi[v] = m_hi[v][bus_wdata[7:0]];
          end
        end
        e_lo[v] = m_lo[v][lk_idx];
        e_hi[v] = m_hi[v][lk_idx];
      end
      if (bus_wr && bus_addr == 4'h8) m_idx = bus_wdata[7:0];
    end
  end

  task automatic cmp(string what, bit [63:0] got, bit [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", phase, what, got, exp);
    end
  endtask

  task automatic check_all();
    for (int v = 0; v < 2; v++) begin
      bit [31:0] er;
      case (bus_addr)
        4'h0: er = s_lo[v];
        4'h4: er = s_hi[v];
        4'h8: er = {24'h0, m_idx};
        default: er = 0;
      endcase
      cmp(v == 0 ? "rdata" : "rdata(no-endian)", 64'(rd[v]), 64'(er));
      cmp(v == 0 ? "lookup" : "lookup(no-endian)",
          64'({base[v], width[v], height[v], wrap[v], blk[v], endn[v]}),
          64'({e_lo[v][28:0], e_hi[v][8:0], e_lo[v][31:29], e_hi[v][21:9],
               e_hi[v][23:22], e_hi[v][25:24], e_hi[v][29:26]}));
    end
  endtask

  task automatic cyc(bit wr, bit [3:0] a, bit [31:0] d, bit [7:0] li);
    @(negedge clk);
    check_all();
    bus_wr = wr; bus_addr = a; bus_wdata = d; lk_idx = li;
  endtask

  task automatic put(bit [31:0] lo, bit [31:0] hi, bit [7:0] idx);
    cyc(1, 4'h0, lo, idx);
    cyc(1, 4'h4, hi, idx);
    cyc(1, 4'h8, 32'h200 | 32'(idx), idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    phase = "R1";
    for (int i = 0; i < 4; i++) cyc(0, 4'(i * 4), 0, 8'(i * 85));
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 4'(i * 4), 0, 8'(i * 85));

    phase = "R2";
    cyc(1, 4'h0, 32'hDEAD_BEEF, 0);
    cyc(1, 4'h4, 32'h0123_4567, 0);
    cyc(0, 4'h0, 0, 0);
    cyc(0, 4'h4, 0, 0);
    cyc(1, 4'hC, 32'hFFFF_FFFF, 0);
    cyc(1, 4'h1, 32'hFFFF_FFFF, 0);
    cyc(0, 4'hC, 0, 0);
    cyc(0, 4'h0, 0, 0);

    phase = "R4";
    put(32'hA000_0001, 32'h0000_01FF, 8'd5);
    cyc(0, 4'h0, 0, 8'd5);
    cyc(0, 4'h0, 0, 8'd5);

    phase = "R5";
    put(32'h1FFF_FFFF, 32'hC3FF_FE00, 8'd6);
    cyc(0, 4'h4, 0, 8'd6);
    cyc(0, 4'h4, 0, 8'd6);

    phase = "R6";
    put(32'h0, 32'hFFFF_FFFF, 8'd7);
    cyc(0, 4'h4, 0, 8'd7);
    cyc(0, 4'h4, 0, 8'd7);

    phase = "R3";
    put(32'h1234_5678, 32'h2ABC_DEF0, 8'd0);
    cyc(0, 4'h4, 0, 8'd0);
    put(32'h8765_4321, 32'h1555_AAAA, 8'd255);
    cyc(0, 4'h4, 0, 8'd255);
    cyc(0, 4'h4, 0, 8'd1);
    cyc(0, 4'h4, 0, 8'd0);

    phase = "R9";
    for (int i = 250; i < 256; i++) cyc(0, 4'h0, 0, 8'(i));
    cyc(0, 4'h0, 0, 8'd5);

    phase = "R10";
    cyc(1, 4'h0, 32'h5555_0009, 8'd9);
    cyc(1, 4'h4, 32'h0AAA_5555, 8'd9);
    cyc(1, 4'h8, 32'h209, 8'd9);
    cyc(0, 4'h0, 0, 8'd9);
    cyc(0, 4'h0, 0, 8'd9);

    phase = "R7";
    cyc(1, 4'h0, 32'h0, 8'd0);
    cyc(1, 4'h4, 32'h0, 8'd0);
    cyc(1, 4'h8, 32'h105, 8'd0);
    cyc(0, 4'h0, 0, 8'd0);
    cyc(0, 4'h4, 0, 8'd0);
    cyc(1, 4'h8, 32'h1FF, 8'd0);
    cyc(0, 4'h0, 0, 8'd0);
    cyc(0, 4'h4, 0, 8'd0);
    cyc(1, 4'h8, 32'h30C, 8'd12);
    cyc(0, 4'h0, 0, 8'd12);
    cyc(0, 4'h4, 0, 8'd12);
    cyc(0, 4'h4, 0, 8'd12);

    phase = "R8";
    cyc(1, 4'h8, 32'hABCD_0C42, 8'd0);
    cyc(0, 4'h8, 0, 8'd0);
    cyc(0, 4'h8, 0, 8'd0);

    phase = "R3";
    for (int n = 0; n < 3000; n++) begin
      bit [31:0] r = $urandom;
      bit [7:0] ix = 8'($urandom_range(0, 3));
      bit [31:0] d = $urandom;
      case (r[2:0])
        3'd0, 3'd1: cyc(1, 4'h0, d, ix);
        3'd2, 3'd3: cyc(1, 4'h4, d, ix);
        3'd4: cyc(1, 4'h8, {d[31:10], d[9:8], 6'h0, ix}, ix);
        3'd5: cyc(1, 4'h8, {22'h0, 2'b10, ix}, ix);
        default: cyc(0, 4'(r[5:4] * 4), 0, ix);
      endcase
    end
    cyc(0, 4'h0, 0, 0);
    cyc(0, 4'h0, 0, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule